// File: doc/BRIEF.md
# Write-Leveling Mode Register Sequencer

This block walks the ranks of one memory channel and hands out, one at a time, the extended mode register 1 command word each populated rank needs to go into or come out of write-leveling mode for a single target rank. A controller pulses `start_i` with the direction (`enter_i`), the target rank, the populated-rank mask, a 3-bit configuration index and the normal termination code of every rank. The block then offers one command per populated rank, lowest rank first, on a valid/ready handshake, and pulses `done_o` when the last one has been taken.

Every word carries a termination code shifted up by two with bit 1 forced high. On entry the termination code is looked up in a parameter table indexed by configuration, target rank and the rank being written. The target rank also gets the write-level enable bit (bit 7), and every other rank gets its output buffer turned off (bit 12). On exit each rank gets back its normal code and neither extra bit. A termination code outside the known set is still issued, and it raises a warning flag. Timing of the commands on the memory bus is left to the consumer of the handshake.

Top module: `wlvl_mr_seq`

## Requirements
- R1: After reset `cmd_valid_o`, `done_o` and `odt_warn_o` are low.
- R2: After a start, exactly one command is offered for each rank whose bit is set in the mask, in ascending rank order. Ranks whose bit is clear are skipped. `cmd_rank_o` names the rank being written.
- R3: While `cmd_valid_o` is high and `cmd_ready_i` is low, valid, rank and word hold their values.
- R4: The command word equals the 8-bit termination code shifted left by two, with bit 1 set and bit 0 clear, plus the mode bits of R6 and R7.
- R5: In enter mode the termination code is the table entry at index ((config*4 + target)*4 + rank). In exit mode it is the normal code of that rank, taken from `norm_odt_i[rank*8 +: 8]`.
- R6: In enter mode the word for the target rank has bit 7 set and bit 12 clear.
- R7: In enter mode the word for every non-target rank has bit 12 set.
- R8: In exit mode the word is exactly the normal code shifted by two with bit 1 set.
- R9: `done_o` is high for exactly one cycle, in the cycle after the last command is accepted. With an empty mask it is high in the cycle after the start, and no command is offered.
- R10: The known termination codes are 0x00 (off), 0x01 (60 ohm), 0x10 (120 ohm), 0x11 (40 ohm), 0x80 (20 ohm) and 0x81 (30 ohm). A command carrying any other code is still issued. Its acceptance sets `odt_warn_o`, which stays high until the next accepted start.
- R11: A start pulse or any input change while a sequence is running has no effect on that sequence. All parameters are captured on the accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start_i | input | 1 | Starts a sequence when idle |
| enter_i | input | 1 | 1 = enter write leveling, 0 = exit |
| target_i | input | 2 | Rank being leveled |
| pop_mask_i | input | 4 | Populated ranks, bit n = rank n |
| cfg_i | input | 3 | Configuration index into the entry table |
| norm_odt_i | input | 32 | Normal termination code per rank, 8 bits each |
| cmd_valid_o | output | 1 | Command offered |
| cmd_ready_i | input | 1 | Command taken when valid is high |
| cmd_rank_o | output | 2 | Rank the command is addressed to |
| cmd_word_o | output | 16 | Mode register 1 command word |
| done_o | output | 1 | One-cycle pulse after the last command |
| odt_warn_o | output | 1 | Sticky flag for an undefined termination code |

## Verification
Random masks, targets, configurations and directions cover sparse masks with gaps, a full mask and the target rank that is not populated. These cases separate a correct skip-and-ascend walk from one that visits ranks in order or stops early. Entry and exit sequences on the same ranks show whether the lookup source and the two mode bits follow the direction flag and the target. Random ready stalls, together with a start pulse and changed inputs issued in the middle of a sequence, show that commands hold and that captured parameters do not move. Undefined normal codes, followed by a clean sequence, tell a sticky-until-restart warning apart from one that never sets or never clears.

// File: rtl/wlvl_pkg.sv
// Shared constants, state type and the default entry-mode termination table.
// Assumes 8 configurations, 4 ranks and 8-bit termination codes for the default table.
package wlvl_pkg;

    localparam int P_NRANK = 4;
    localparam int P_NCFG  = 8;
    localparam int P_OW    = 8;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_ISSUE = 1'b1
    } wl_state_t;

    // Default table: target gets 40 ohm, its DIMM partner is off,
    // ranks on the other DIMM park at 60 or 120 ohm by configuration parity.
    function automatic logic [P_NCFG*P_NRANK*P_NRANK*P_OW-1:0] wl_default_tbl();
        logic [P_NCFG*P_NRANK*P_NRANK*P_OW-1:0] tbl;
        tbl = '0;
        for (int c = 0; c < P_NCFG; c++) begin
            for (int t = 0; t < P_NRANK; t++) begin
                for (int r = 0; r < P_NRANK; r++) begin
                    logic [P_OW-1:0] code;
                    if (r == t)
                        code = 8'h11;
                    else if ((r / 2) == (t / 2))
                        code = 8'h00;
                    else if ((c % 2) == 1)
                        code = 8'h01;
                    else
                        code = 8'h10;
                    tbl[((c*P_NRANK + t)*P_NRANK + r)*P_OW +: P_OW] = code;
                end
            end
        end
        return tbl;
    endfunction

endpackage

// File: rtl/wlvl_rank_pick.sv
// Finds the lowest populated rank above the current one, or the lowest
// populated rank at all when first_i is set. Purely combinational.
module wlvl_rank_pick #(
    parameter int NRANK = 4,
    localparam int RW = $clog2(NRANK)
) (
    input  logic [NRANK-1:0] mask_i,
    input  logic [RW-1:0]    cur_i,
    input  logic             first_i,
    output logic [RW-1:0]    nxt_o,
    output logic             found_o
);

    // Scan from the top down so the lowest qualifying rank wins.
    always_comb begin
        nxt_o   = '0;
        found_o = 1'b0;
        for (int i = NRANK - 1; i >= 0; i--) begin
            if (mask_i[i] && (first_i || (i > int'(cur_i)))) begin
                nxt_o   = RW'(i);
                found_o = 1'b1;
            end
        end
    end

endmodule

// File: rtl/wlvl_word_build.sv
// Assembles the mode register 1 command word for one rank and flags an
// undefined termination code. Assumes 8-bit codes. Purely combinational.
module wlvl_word_build #(
    parameter int NRANK      = 4,
    parameter int NCFG       = 8,
    parameter int OW         = 8,
    parameter int CW         = 16,
    parameter int WL_BIT     = 7,
    parameter int QOFF_BIT   = 12,
    parameter int CODE_SHIFT = 2,
    parameter logic [NCFG*NRANK*NRANK*OW-1:0] TBL = '0,
    localparam int RW   = $clog2(NRANK),
    localparam int CFGW = $clog2(NCFG)
) (
    input  logic                enter_i,
    input  logic [RW-1:0]       target_i,
    input  logic [RW-1:0]       rank_i,
    input  logic [CFGW-1:0]     cfg_i,
    input  logic [NRANK*OW-1:0] norm_i,
    output logic [CW-1:0]       word_o,
    output logic                undef_o
);

    logic [OW-1:0] code;
    logic [CW-1:0] wide;

    // Select the code source by direction.
    always_comb begin
        if (enter_i)
            code = TBL[((int'(cfg_i)*NRANK + int'(target_i))*NRANK + int'(rank_i))*OW +: OW];
        else
            code = norm_i[int'(rank_i)*OW +: OW];
    end

    // Shift the code into place, force bit 1, add the mode bits.
    always_comb begin
        wide   = {{(CW-OW){1'b0}}, code};
        word_o = (wide << CODE_SHIFT) | CW'(2);
        if (enter_i) begin
            if (rank_i == target_i)
                word_o[WL_BIT] = 1'b1;
            else
                word_o[QOFF_BIT] = 1'b1;
        end
    end

    // Flag any code outside the known set.
    always_comb begin
        case (code)
            8'h00, 8'h01, 8'h10, 8'h11, 8'h80, 8'h81: undef_o = 1'b0;
            default:                                 undef_o = 1'b1;
        endcase
    end

endmodule

// File: rtl/wlvl_mr_seq.sv
// Issues one mode register 1 command per populated rank, lowest first, to
// enter or leave write leveling for a target rank. Parameters are captured on
// the accepted start. Commands are held until taken. Assumes a 4-rank default
// table unless WL_ODT_TBL is overridden.
module wlvl_mr_seq #(
    parameter int NRANK      = wlvl_pkg::P_NRANK,
    parameter int NCFG       = wlvl_pkg::P_NCFG,
    parameter int OW         = wlvl_pkg::P_OW,
    parameter int CW         = 16,
    parameter int WL_BIT     = 7,
    parameter int QOFF_BIT   = 12,
    parameter int CODE_SHIFT = 2,
    parameter logic [NCFG*NRANK*NRANK*OW-1:0] WL_ODT_TBL = wlvl_pkg::wl_default_tbl(),
    localparam int RW   = $clog2(NRANK),
    localparam int CFGW = $clog2(NCFG)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start_i,
    input  logic                enter_i,
    input  logic [RW-1:0]       target_i,
    input  logic [NRANK-1:0]    pop_mask_i,
    input  logic [CFGW-1:0]     cfg_i,
    input  logic [NRANK*OW-1:0] norm_odt_i,
    output logic                cmd_valid_o,
    input  logic                cmd_ready_i,
    output logic [RW-1:0]       cmd_rank_o,
    output logic [CW-1:0]       cmd_word_o,
    output logic                done_o,
    output logic                odt_warn_o
);
    import wlvl_pkg::*;

    wl_state_t          state_q;
    logic [RW-1:0]      rank_q;
    logic               enter_q;
    logic [RW-1:0]      target_q;
    logic [NRANK-1:0]   mask_q;
    logic [CFGW-1:0]    cfg_q;
    logic [NRANK*OW-1:0] norm_q;
    logic               done_q;
    logic               warn_q;

    logic               idle;
    logic [NRANK-1:0]   pick_mask;
    logic [RW-1:0]      pick_nxt;
    logic               pick_found;
    logic               undef;

    // On start the picker scans the incoming mask, afterwards the captured one.
    assign idle      = (state_q == ST_IDLE);
    assign pick_mask = idle ? pop_mask_i : mask_q;

    wlvl_rank_pick #(.NRANK(NRANK)) u_pick (
        .mask_i  (pick_mask),
        .cur_i   (rank_q),
        .first_i (idle),
        .nxt_o   (pick_nxt),
        .found_o (pick_found)
    );

    wlvl_word_build #(
        .NRANK(NRANK), .NCFG(NCFG), .OW(OW), .CW(CW),
        .WL_BIT(WL_BIT), .QOFF_BIT(QOFF_BIT), .CODE_SHIFT(CODE_SHIFT),
        .TBL(WL_ODT_TBL)
    ) u_word (
        .enter_i  (enter_q),
        .target_i (target_q),
        .rank_i   (rank_q),
        .cfg_i    (cfg_q),
        .norm_i   (norm_q),
        .word_o   (cmd_word_o),
        .undef_o  (undef)
    );

    // Sequence control: capture on start, step on each accepted command.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            rank_q   <= '0;
            enter_q  <= 1'b0;
            target_q <= '0;
            mask_q   <= '0;
            cfg_q    <= '0;
            norm_q   <= '0;
            done_q   <= 1'b0;
            warn_q   <= 1'b0;
        end else begin
            done_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start_i) begin
                        enter_q  <= enter_i;
                        target_q <= target_i;
                        mask_q   <= pop_mask_i;
                        cfg_q    <= cfg_i;
                        norm_q   <= norm_odt_i;
                        warn_q   <= 1'b0;
                        if (pick_found) begin
                            rank_q  <= pick_nxt;
                            state_q <= ST_ISSUE;
                        end else begin
                            done_q <= 1'b1;
                        end
                    end
                end
                ST_ISSUE: begin
                    if (cmd_ready_i) begin
                        if (undef)
                            warn_q <= 1'b1;
                        if (pick_found) begin
                            rank_q <= pick_nxt;
                        end else begin
                            state_q <= ST_IDLE;
                            done_q  <= 1'b1;
                        end
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign cmd_valid_o = (state_q == ST_ISSUE);
    assign cmd_rank_o  = rank_q;
    assign done_o      = done_q;
    assign odt_warn_o  = warn_q;

endmodule

// File: rtl/wlvl_mr_seq_chk.sv
// Protocol and word-format checks for wlvl_mr_seq, attached by bind.
// Assumes it sees the captured direction, target and mask of the sequencer.
module wlvl_mr_seq_chk #(
    parameter int NRANK = 4,
    parameter int CW    = 16,
    localparam int RW   = $clog2(NRANK)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cmd_valid_o,
    input logic             cmd_ready_i,
    input logic [RW-1:0]    cmd_rank_o,
    input logic [CW-1:0]    cmd_word_o,
    input logic             done_o,
    input logic             enter_q,
    input logic [RW-1:0]    target_q,
    input logic [NRANK-1:0] mask_q
);

    p_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o && !cmd_ready_i |=> cmd_valid_o && $stable(cmd_rank_o) && $stable(cmd_word_o));

    p_ascend_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o && cmd_ready_i |=> !cmd_valid_o || (cmd_rank_o > $past(cmd_rank_o)));

    p_populated_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> mask_q[cmd_rank_o]);

    p_fixed_bits_r4: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o |-> cmd_word_o[1] && !cmd_word_o[0]);

    p_target_wl_r6: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o && enter_q && (cmd_rank_o == target_q) |-> cmd_word_o[7] && !cmd_word_o[12]);

    p_other_qoff_r7: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o && enter_q && (cmd_rank_o != target_q) |-> cmd_word_o[12]);

    p_done_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    p_done_idle_r9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> !cmd_valid_o);

    p_capture_r11: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid_o && !cmd_ready_i |=> $stable(enter_q) && $stable(target_q) && $stable(mask_q));

endmodule

bind wlvl_mr_seq wlvl_mr_seq_chk #(.NRANK(NRANK), .CW(CW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .cmd_valid_o (cmd_valid_o),
    .cmd_ready_i (cmd_ready_i),
    .cmd_rank_o  (cmd_rank_o),
    .cmd_word_o  (cmd_word_o),
    .done_o      (done_o),
    .enter_q     (enter_q),
    .target_q    (target_q),
    .mask_q      (mask_q)
);

// File: tb/test_wlvl_mr_seq.sv
`timescale 1ns/1ps
module test_wlvl_mr_seq;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic        enter_i = 1'b0;
    logic [1:0]  target_i = '0;
    logic [3:0]  pop_mask_i = '0;
    logic [2:0]  cfg_i = '0;
    logic [31:0] norm_odt_i = '0;
    logic        cmd_valid_o;
    logic        cmd_ready_i = 1'b0;
    logic [1:0]  cmd_rank_o;
    logic [15:0] cmd_word_o;
    logic        done_o;
    logic        odt_warn_o;

    int checks = 0;
    int errors = 0;
    int cyc    = 0;
    bit ended  = 0;

    always #2 clk = ~clk;

    wlvl_mr_seq i_wlvl_mr_seq (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .enter_i(enter_i),
        .target_i(target_i), .pop_mask_i(pop_mask_i), .cfg_i(cfg_i),
        .norm_odt_i(norm_odt_i), .cmd_valid_o(cmd_valid_o), .cmd_ready_i(cmd_ready_i),
        .cmd_rank_o(cmd_rank_o), .cmd_word_o(cmd_word_o), .done_o(done_o),
        .odt_warn_o(odt_warn_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    // Entry table as stated for the default build (R5).
    function automatic bit [7:0] tb_tbl(input bit [2:0] c, input bit [1:0] t, input bit [1:0] r);
        if (r == t) return 8'h11;
        if (r[1] == t[1]) return 8'h00;
        return c[0] ? 8'h01 : 8'h10;
    endfunction

    function automatic bit tb_known(input bit [7:0] code);
        return code inside {8'h00, 8'h01, 8'h10, 8'h11, 8'h80, 8'h81};
    endfunction

    function automatic bit [15:0] tb_word(input bit en, input bit [1:0] t, input bit [1:0] r, input bit [7:0] code);
        bit [15:0] w;
        w = ({8'h00, code} << 2) | 16'h0002;
        if (en) begin
            if (r == t) w[7] = 1'b1;
            else        w[12] = 1'b1;
        end
        return w;
    endfunction

    function automatic bit [7:0] rnd_code();
        bit [7:0] pool [8] = '{8'h00, 8'h01, 8'h10, 8'h11, 8'h80, 8'h81, 8'h91, 8'h33};
        return pool[$urandom % 8];
    endfunction

    task automatic check_cmd(input bit en, input bit [1:0] t, input bit [1:0] r, input bit [7:0] code);
        bit [15:0] ew;
        ew = tb_word(en, t, r, code);
        chk(cmd_valid_o == 1'b1, "R2 valid", int'(cmd_valid_o), 1);
        chk(cmd_rank_o == r, "R2 rank", int'(cmd_rank_o), int'(r));
        chk(cmd_word_o == ew, en ? ((r == t) ? "R6 word" : "R7 word") : "R8 word",
            int'(cmd_word_o), int'(ew));
        chk(cmd_word_o[1] == 1'b1, "R4 bit1", int'(cmd_word_o[1]), 1);
    endtask

    task automatic run_seq(input bit en, input bit [1:0] t, input bit [3:0] m,
                           input bit [2:0] c, input bit [31:0] nc, input bit poke);
        bit exp_warn;
        int last;
        bit first;
        @(negedge clk);
        enter_i = en; target_i = t; pop_mask_i = m; cfg_i = c; norm_odt_i = nc;
        start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        // Scramble the live inputs; the captured copy must win (R11).
        enter_i = ~en; target_i = t + 2'd1; pop_mask_i = ~m; cfg_i = c + 3'd1;
        norm_odt_i = ~nc;
        exp_warn = 1'b0;
        if (m == 4'b0000) begin
            chk(done_o == 1'b1, "R9 empty done", int'(done_o), 1);
            chk(cmd_valid_o == 1'b0, "R9 empty no cmd", int'(cmd_valid_o), 0);
            @(negedge clk);
            chk(done_o == 1'b0, "R9 empty pulse", int'(done_o), 0);
            chk(odt_warn_o == 1'b0, "R10 cleared", int'(odt_warn_o), 0);
            return;
        end
        last = 0;
        for (int r = 0; r < 4; r++) if (m[r]) last = r;
        first = 1'b1;
        for (int r = 0; r < 4; r++) begin
            bit [7:0] code;
            int stalls;
            if (!m[r]) continue;
            code = en ? tb_tbl(c, t, 2'(r)) : nc[r*8 +: 8];
            if (!tb_known(code)) exp_warn = 1'b1;
            stalls = int'($urandom % 3) + ((poke && first) ? 1 : 0);
            for (int s = 0; s < stalls; s++) begin
                check_cmd(en, t, 2'(r), code);
                cmd_ready_i = 1'b0;
                if (poke && first && s == 0) start_i = 1'b1;
                @(negedge clk);
                start_i = 1'b0;
                chk(cmd_valid_o == 1'b1, "R3 held", int'(cmd_valid_o), 1);
            end
            check_cmd(en, t, 2'(r), code);
            cmd_ready_i = 1'b1;
            @(negedge clk);
            cmd_ready_i = 1'b0;
            first = 1'b0;
            if (r == last) begin
                chk(done_o == 1'b1, "R9 done", int'(done_o), 1);
                chk(cmd_valid_o == 1'b0, "R2 no extra cmd", int'(cmd_valid_o), 0);
                chk(odt_warn_o == exp_warn, "R10 warn", int'(odt_warn_o), int'(exp_warn));
                @(negedge clk);
                chk(done_o == 1'b0, "R9 pulse width", int'(done_o), 0);
                chk(odt_warn_o == exp_warn, "R10 sticky", int'(odt_warn_o), int'(exp_warn));
            end else begin
                chk(done_o == 1'b0, "R9 early done", int'(done_o), 0);
            end
        end
    endtask

    // Watchdog: a hung run is a failed check.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !ended) begin
            ended = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=<150000", cyc);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h1d5e_a7c3));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(cmd_valid_o == 1'b0, "R1 valid", int'(cmd_valid_o), 0);
        chk(done_o == 1'b0, "R1 done", int'(done_o), 0);
        chk(odt_warn_o == 1'b0, "R1 warn", int'(odt_warn_o), 0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(cmd_valid_o == 1'b0, "R1 idle after reset", int'(cmd_valid_o), 0);

        // Directed corners.
        run_seq(1'b1, 2'd2, 4'b1111, 3'd0, 32'h11_10_01_00, 1'b0); // R6 R7 full mask
        run_seq(1'b0, 2'd2, 4'b1111, 3'd0, 32'h81_80_11_10, 1'b0); // R8 exit, R5 normal codes
        run_seq(1'b1, 2'd0, 4'b0000, 3'd5, 32'h0, 1'b0);           // R9 empty mask
        run_seq(1'b1, 2'd1, 4'b1100, 3'd3, 32'h0, 1'b0);           // R7 target unpopulated
        run_seq(1'b0, 2'd0, 4'b1010, 3'd1, 32'h91_00_33_00, 1'b0); // R10 undefined codes, R2 gaps
        run_seq(1'b0, 2'd0, 4'b0101, 3'd1, 32'h00_11_00_10, 1'b0); // R10 cleared by new start
        run_seq(1'b1, 2'd3, 4'b1001, 3'd7, 32'h0, 1'b1);           // R11 start while busy

        // Random sequences (R2 R3 R5 R10).
        for (int n = 0; n < 60; n++) begin
            bit [31:0] nc;
            nc = {rnd_code(), rnd_code(), rnd_code(), rnd_code()};
            run_seq(1'($urandom), 2'($urandom), 4'($urandom), 3'($urandom), nc,
                    1'(($urandom % 5) == 0));
        end

        if (!ended) begin
            ended = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule